// File: doc/BRIEF.md
# SHA-1 Message Schedule Generator

This block supplies the 32-bit schedule word for each of the 80 rounds of a SHA-1 compression pass. It takes a 512-bit block and a round number. It does not keep all 80 words. It keeps a 16-entry window of words. Words for rounds 0 to 15 are read straight from that window. Each word for rounds 16 to 79 is built in the cycle it is requested and written back over the window slot it replaces.

The round engine pulses `init` with the block present. From the next cycle it steps `round_addr` by one per cycle, from 0 through 79, and reads `w` combinationally in each cycle. Reset is synchronous and active high.

Top module: `sha1_msg_sched`

## Requirements
- R1: A cycle with `rst` high sets all 16 window slots to zero. Until the next `init`, `w` reads 0 for every address, and reset takes priority over `init` in the same cycle.
- R2: A cycle with `init` high loads the window from `block`. Slot k receives bits [511-32k -: 32], so `block[511:480]` is the round-0 word.
- R3: For `round_addr` 0 to 15 with `init` low, `w` equals window slot `round_addr` and no slot changes, so reading the same address twice returns the same value.
- R4: For `round_addr` t in 16 to 79, `w` equals rotl1(W[t-3] xor W[t-8] xor W[t-14] xor W[t-16]) in that same cycle, where rotl1 is a left rotate by one bit of a 32-bit word.
- R5: For `round_addr` t in 16 to 79 with `init` low, the word presented on `w` is stored into slot t mod 16 at the clock edge. A run stepping t from 0 to 79 therefore yields the full 80-word schedule.
- R6: For `round_addr` 80 to 127, `w` is 0 and no window slot changes.
- R7: After a run up to round 79, reading addresses 0 to 15 returns the words of rounds 64 to 79, slot k holding round 64+k.
- R8: When `init` is high, the block load wins over any write-back, whatever `round_addr` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| init | input | 1 | Load the window from `block` at this edge |
| block | input | 512 | Message block, round-0 word in the top 32 bits |
| round_addr | input | 7 | Round number whose schedule word is requested |
| w | output | 32 | Schedule word for `round_addr` |

## Verification
A reference schedule built from the plain 80-entry recurrence is compared against every round of two different blocks. A wrong tap offset or a missing rotate would corrupt rounds 16 and up. A write-back to the wrong slot would only show a few rounds later, where that slot is used as a tap.

After a run, out-of-range addresses are read, and then slots 0 to 15 are read back. A design that wrote on addresses 80 and above, or left stale data in the window, would fail those reads.

`init` is pulsed while the address sits in the expansion range. A design that let the write-back beat the load would corrupt one slot of the new block.

`rst` and `init` are raised together. A design that gave `init` priority would show block data instead of zeros.

// File: rtl/sha1_sched_pkg.sv
package sha1_sched_pkg;
    localparam int WORD_W    = 32;
    localparam int WIN_DEPTH = 16;
    localparam int ROUNDS    = 80;
    localparam int ADDR_W    = 7;
    localparam int IDX_W     = $clog2(WIN_DEPTH);
    localparam int BLOCK_W   = WORD_W * WIN_DEPTH;

    // Tap distances of the expansion recurrence
    localparam int TAP_A = 3;
    localparam int TAP_B = 8;
    localparam int TAP_C = 14;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [WIN_DEPTH-1:0][WORD_W-1:0] window_t;

    typedef enum logic [1:0] {
        PH_DIRECT,
        PH_EXPAND,
        PH_BEYOND
    } phase_e;

    typedef struct packed {
        idx_t t_a;
        idx_t t_b;
        idx_t t_c;
        idx_t t_self;
    } taps_t;

    function automatic word_t rotl1(input word_t x);
        return {x[WORD_W-2:0], x[WORD_W-1]};
    endfunction

    // Window slot indices wrap modulo WIN_DEPTH through IDX_W arithmetic
    function automatic taps_t taps_of(input idx_t i);
        taps_t t;
        t.t_a    = idx_t'(i - idx_t'(TAP_A));
        t.t_b    = idx_t'(i - idx_t'(TAP_B));
        t.t_c    = idx_t'(i - idx_t'(TAP_C));
        t.t_self = i;
        return t;
    endfunction

    function automatic phase_e classify(input addr_t a);
        if (int'(a) < WIN_DEPTH)   return PH_DIRECT;
        else if (int'(a) < ROUNDS) return PH_EXPAND;
        else                       return PH_BEYOND;
    endfunction
endpackage

// File: rtl/sha1_sched_win.sv
module sha1_sched_win
    import sha1_sched_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load_i,
    input  logic [BLOCK_W-1:0]   block_i,
    input  logic                 we_i,
    input  idx_t                 widx_i,
    input  word_t                wdata_i,
    output window_t              win_o
);
    window_t win_q;

    for (genvar k = 0; k < WIN_DEPTH; k++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                win_q[k] <= '0;
            end else if (load_i) begin
                win_q[k] <= block_i[BLOCK_W-1-k*WORD_W -: WORD_W];
            end else if (we_i && widx_i == idx_t'(k)) begin
                win_q[k] <= wdata_i;
            end
        end
    end

    assign win_o = win_q;

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (win_q == '0));

    // R2
    load_first_word_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (win_q[0] == $past(block_i[BLOCK_W-1 -: WORD_W])));

    // R3
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !we_i) |=> $stable(win_q));

    // R5
    write_back_chk: assert property (@(posedge clk) disable iff (rst)
        (we_i && !load_i) |=> (win_q[$past(widx_i)] == $past(wdata_i)));
endmodule

// File: rtl/sha1_sched_expand.sv
module sha1_sched_expand
    import sha1_sched_pkg::*;
(
    input  window_t win_i,
    input  idx_t    idx_i,
    output word_t   next_o
);
    taps_t tp;
    word_t mix;

    always_comb begin
        tp     = taps_of(idx_i);
        mix    = win_i[tp.t_a] ^ win_i[tp.t_b] ^ win_i[tp.t_c] ^ win_i[tp.t_self];
        next_o = rotl1(mix);
    end
endmodule

// File: rtl/sha1_msg_sched.sv
module sha1_msg_sched
    import sha1_sched_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               init,
    input  logic [BLOCK_W-1:0] block,
    input  logic [ADDR_W-1:0]  round_addr,
    output logic [WORD_W-1:0]  w
);
    window_t win;
    word_t   expanded;
    idx_t    slot;
    phase_e  phase;
    logic    win_we;

    assign slot  = idx_t'(round_addr);
    assign phase = classify(round_addr);

    // Write-back only while expanding, and never against a load
    assign win_we = (phase == PH_EXPAND) && !init;

    sha1_sched_win i_win (
        .clk     (clk),
        .rst     (rst),
        .load_i  (init),
        .block_i (block),
        .we_i    (win_we),
        .widx_i  (slot),
        .wdata_i (expanded),
        .win_o   (win)
    );

    sha1_sched_expand i_expand (
        .win_i  (win),
        .idx_i  (slot),
        .next_o (expanded)
    );

    always_comb begin
        unique case (phase)
            PH_DIRECT: w = win[slot];
            PH_EXPAND: w = expanded;
            default:   w = '0;
        endcase
    end

    // R6
    beyond_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(round_addr) >= ROUNDS) |-> (!win_we && w == '0));

    // R8
    init_over_write_chk: assert property (@(posedge clk) disable iff (rst)
        init |-> !win_we);
endmodule

// File: tb/test_sha1_msg_sched.sv
`timescale 1ns/1ps
module test_sha1_msg_sched;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         init = 1'b0;
    logic [511:0] block = '0;
    logic [6:0]   round_addr = '0;
    logic [31:0]  w;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    int          req_q[$];
    event        mon_ev;

    logic [31:0] ref_a[80];
    logic [31:0] ref_b[80];
    logic [511:0] blk_a, blk_b;

    always #5 clk = ~clk;

    sha1_msg_sched i_sha1_msg_sched (
        .clk(clk), .rst(rst), .init(init), .block(block),
        .round_addr(round_addr), .w(w)
    );

    function automatic logic [31:0] rl1(input logic [31:0] x);
        return {x[30:0], x[31]};
    endfunction

    task automatic build_ref(input logic [511:0] b, output logic [31:0] r[80]);
        for (int t = 0; t < 80; t++) begin
            if (t < 16) r[t] = b[511-32*t -: 32];
            else        r[t] = rl1(r[t-3] ^ r[t-8] ^ r[t-14] ^ r[t-16]);
        end
    endtask

    // Driver: apply inputs after a falling edge, push the expected word
    task automatic step(input logic [6:0] a, input logic i, input logic [511:0] b,
                        input bit chk, input logic [31:0] e, input int req);
        @(negedge clk);
        round_addr = a;
        init       = i;
        block      = b;
        if (chk) begin
            #1;
            exp_q.push_back(e);
            req_q.push_back(req);
            -> mon_ev;
        end
    endtask

    // Monitor: pop and compare while the output is settled
    always begin
        @(mon_ev);
        while (exp_q.size() > 0) begin
            logic [31:0] e;
            int rq;
            e  = exp_q.pop_front();
            rq = req_q.pop_front();
            checks++;
            if (w !== e) begin
                failures++;
                $display("FAIL R%0d addr=%0d actual=%h expected=%h", rq, round_addr, w, e);
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        blk_a = 512'h61626380000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000018;
        for (int k = 0; k < 16; k++)
            blk_b[511-32*k -: 32] = (32'h9E3779B9 * (k + 1)) ^ (32'(k) << 24);
        build_ref(blk_a, ref_a);
        build_ref(blk_b, ref_b);

        repeat (2) @(negedge clk);
        rst = 1'b0;

        // R1: window cleared after reset
        for (int k = 0; k < 16; k++) step(7'(k), 1'b0, '0, 1'b1, 32'h0, 1);

        // R2 direct words, R4/R5 expanded words, block A
        step(7'd0, 1'b1, blk_a, 1'b0, 32'h0, 2);
        for (int t = 0; t < 80; t++)
            step(7'(t), 1'b0, blk_a, 1'b1, ref_a[t], (t < 16) ? 2 : 4);

        // R6: out-of-range addresses read zero
        step(7'd80,  1'b0, blk_a, 1'b1, 32'h0, 6);
        step(7'd100, 1'b0, blk_a, 1'b1, 32'h0, 6);
        step(7'd127, 1'b0, blk_a, 1'b1, 32'h0, 6);

        // R7: window now holds rounds 64..79 (also shows R6 wrote nothing)
        for (int k = 0; k < 16; k++) step(7'(k), 1'b0, blk_a, 1'b1, ref_a[64+k], 7);

        // R3: repeated direct read is stable
        step(7'd5, 1'b0, blk_a, 1'b1, ref_a[69], 3);
        step(7'd5, 1'b0, blk_a, 1'b1, ref_a[69], 3);

        // R8: init while address is in the expansion range
        step(7'd30, 1'b1, blk_b, 1'b0, 32'h0, 8);
        step(7'd14, 1'b0, blk_b, 1'b1, ref_b[14], 8);
        for (int t = 0; t < 80; t++)
            step(7'(t), 1'b0, blk_b, 1'b1, ref_b[t], 5);

        // R1: reset wins over a simultaneous init
        @(negedge clk);
        rst = 1'b1; init = 1'b1; block = blk_a; round_addr = 7'd0;
        @(negedge clk);
        rst = 1'b0; init = 1'b0;
        for (int k = 0; k < 16; k++) step(7'(k), 1'b0, blk_a, 1'b1, 32'h0, 1);
        step(7'd16, 1'b0, blk_a, 1'b1, 32'h0, 4);

        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule